// File: doc/BRIEF.md
# SDRAM Mixed-Organization Address Multiplexer

This block converts a linear host word address into the two address presentations an SDRAM controller drives on a shared bus: the row-phase word that opens a row and the column-phase word that selects a location and states whether the access ends with an automatic precharge. It targets a memory module populated with two kinds of chips on the same bus. One kind has 12 row, 8 column and 2 bank address bits. The other has 11 row, 10 column and 1 bank address bit.

In mixed mode, the column phase copies the top row bit and the upper bank bit onto the two column lines just above the 8-bit column field. The wider-column chips therefore receive a complete 10-bit column, while the narrower ones ignore those lines. Any access that opens one of the upper banks is closed with a forced auto-precharge, so that the four-bank chips always have every upper bank closed. In plain mode, neither the copy nor the forced precharge takes place.

The block also raises a flag when the requested word is the last one of a 256-word page, which is the shallowest page among the mixed chips. Every output is registered and is updated only by a request.

Top module: `sdram_mixmux`

## Requirements
- R1: While reset is asserted and after it is released, before any request, `bus_addr_o`, `bank_o`, `page_end_o` and `wr_o` are all zero.
- R2: A request with `phase_col_i`=0 drives the row field (host bits 21:10) on `bus_addr_o[11:0]` and zeros on `bus_addr_o[13:12]` one clock after the request is sampled.
- R3: On every request, in either phase, `bank_o` takes the bank field (host bits 9:8, with host bit 9 on `bank_o[1]`) one clock later.
- R4: A request with `phase_col_i`=1 drives the column field (host bits 7:0) on `bus_addr_o[7:0]` and zeros on `bus_addr_o[11]` and `bus_addr_o[13:12]`.
- R5: In a column-phase request with `mixed_i`=1, `bus_addr_o[8]` equals the top row bit (host bit 21) and `bus_addr_o[9]` equals the upper bank bit (host bit 9).
- R6: In a column-phase request with `mixed_i`=0, `bus_addr_o[9:8]` are zero.
- R7: In a column-phase request with `mixed_i`=1 and host bit 9 high, `bus_addr_o[10]` is 1 whatever the value of `pre_req_i`.
- R8: In every other column-phase request, `bus_addr_o[10]` equals `pre_req_i`.
- R9: `page_end_o` is 1 exactly when the column field of the request is 255, because the next sequential word would cross a 256-word page.
- R10: In a cycle with `req_i` low, no output changes, whatever the other inputs do.
- R11: `wr_o` takes the value of `wr_i` sampled with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe; the other inputs are sampled when it is high |
| host_addr_i | input | 22 | Linear word address: row 21:10, bank 9:8, column 7:0 |
| wr_i | input | 1 | Write (1) or read (0) flag |
| phase_col_i | input | 1 | 0 selects the row phase, 1 selects the column phase |
| mixed_i | input | 1 | 1 selects mixed-organization mapping, 0 selects plain mapping |
| pre_req_i | input | 1 | Host request for auto-precharge |
| bus_addr_o | output | 14 | Multiplexed SDRAM address bus |
| bank_o | output | 2 | SDRAM bank address |
| page_end_o | output | 1 | Request addressed the last word of a 256-word page |
| wr_o | output | 1 | Registered write flag |

## Verification
Each result is due in the first cycle after the clock edge that samples the request, since one output register stands between the inputs and every port. The bench drives inputs on the falling edge and checks the outputs at the next falling edge. At that same falling edge it removes the request and scrambles the other inputs. It then checks at the following falling edge that the registered values have held. The sweep covers both modes, both phases, both precharge values, all four banks, column values at and around the page end, and rows with the top bit set and clear.

// File: rtl/sdram_mixmux_pkg.sv
`timescale 1ns/1ps
package sdram_mixmux_pkg;
  localparam int MM_COL_W  = 8;
  localparam int MM_BANK_W = 2;
  localparam int MM_ROW_W  = 12;
  localparam int MM_BUS_W  = 14;
  localparam int MM_AP_BIT = 10;

  typedef enum logic {PH_ROW = 1'b0, PH_COL = 1'b1} mm_phase_e;
endpackage

// File: rtl/mm_field_split.sv
`timescale 1ns/1ps
module mm_field_split #(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  localparam int HOST_W = COL_W + BANK_W + ROW_W
) (
  input  logic [HOST_W-1:0] host_addr,
  output logic [COL_W-1:0]  col,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row
);
  // column lowest, bank next, row on top
  assign col  = host_addr[COL_W-1:0];
  assign bank = host_addr[COL_W+BANK_W-1:COL_W];
  assign row  = host_addr[HOST_W-1:COL_W+BANK_W];
endmodule

// File: rtl/mm_phase_mux.sv
`timescale 1ns/1ps
module mm_phase_mux #(
  parameter int COL_W  = 8,
  parameter int ROW_W  = 12,
  parameter int BUS_W  = 14,
  parameter int AP_BIT = 10
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic             bank_hi,
  input  logic             phase_col,
  input  logic             mixed,
  input  logic             pre_req,
  output logic [BUS_W-1:0] bus_nxt,
  output logic             ap_forced,
  output logic             page_end_nxt
);
  function automatic logic [BUS_W-1:0] row_word(input logic [ROW_W-1:0] r);
    logic [BUS_W-1:0] w;
    w = '0;
    w[ROW_W-1:0] = r;
    return w;
  endfunction

  function automatic logic want_ap(input logic mx, input logic bhi, input logic pre);
    return (mx & bhi) | pre;
  endfunction

  function automatic logic [BUS_W-1:0] col_word(input logic [COL_W-1:0] c,
                                                input logic r_top,
                                                input logic bhi,
                                                input logic mx,
                                                input logic ap);
    logic [BUS_W-1:0] w;
    w = '0;
    w[COL_W-1:0] = c;
    if (mx) begin
      w[COL_W]   = r_top;
      w[COL_W+1] = bhi;
    end
    w[AP_BIT] = ap;
    return w;
  endfunction

  logic ap_bit;

  assign ap_forced    = mixed & bank_hi;
  assign ap_bit       = want_ap(mixed, bank_hi, pre_req);
  assign page_end_nxt = &col;
  assign bus_nxt      = phase_col ? col_word(col, row[ROW_W-1], bank_hi, mixed, ap_bit)
                                  : row_word(row);

  // the spare lines must stay clear of the precharge line
  always_comb begin
    if (phase_col && ap_forced) begin
      a_forced_ap_r7: assert (bus_nxt[AP_BIT] == 1'b1);
    end
  end
endmodule

// File: rtl/sdram_mixmux.sv
`timescale 1ns/1ps
module sdram_mixmux
  import sdram_mixmux_pkg::*;
#(
  parameter int COL_W  = MM_COL_W,
  parameter int BANK_W = MM_BANK_W,
  parameter int ROW_W  = MM_ROW_W,
  parameter int BUS_W  = MM_BUS_W,
  localparam int HOST_W = COL_W + BANK_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [HOST_W-1:0] host_addr_i,
  input  logic              wr_i,
  input  logic              phase_col_i,
  input  logic              mixed_i,
  input  logic              pre_req_i,
  output logic [BUS_W-1:0]  bus_addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              page_end_o,
  output logic              wr_o
);
  logic [COL_W-1:0]  f_col;
  logic [BANK_W-1:0] f_bank;
  logic [ROW_W-1:0]  f_row;
  logic [BUS_W-1:0]  bus_nxt;
  logic              ap_forced;
  logic              page_end_nxt;
  mm_phase_e         phase;

  assign phase = mm_phase_e'(phase_col_i);

  mm_field_split #(.COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_split (
    .host_addr (host_addr_i),
    .col       (f_col),
    .bank      (f_bank),
    .row       (f_row)
  );

  mm_phase_mux #(.COL_W(COL_W), .ROW_W(ROW_W), .BUS_W(BUS_W), .AP_BIT(MM_AP_BIT)) u_mux (
    .row          (f_row),
    .col          (f_col),
    .bank_hi      (f_bank[BANK_W-1]),
    .phase_col    (phase == PH_COL),
    .mixed        (mixed_i),
    .pre_req      (pre_req_i),
    .bus_nxt      (bus_nxt),
    .ap_forced    (ap_forced),
    .page_end_nxt (page_end_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_addr_o <= '0;
      bank_o     <= '0;
      page_end_o <= 1'b0;
      wr_o       <= 1'b0;
    end else if (req_i) begin
      bus_addr_o <= bus_nxt;
      bank_o     <= f_bank;
      page_end_o <= page_end_nxt;
      wr_o       <= wr_i;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable({bus_addr_o, bank_o, page_end_o, wr_o}));

  p_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> bank_o == $past(host_addr_i[COL_W+BANK_W-1:COL_W]));

  p_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> bus_addr_o[BUS_W-1:ROW_W] == '0);

  p_forced_ap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && phase_col_i && ap_forced |=> bus_addr_o[MM_AP_BIT]);

  p_plain_spare_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && phase_col_i && !mixed_i |=> bus_addr_o[COL_W+1:COL_W] == 2'b00);

  p_page_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> page_end_o == (&$past(host_addr_i[COL_W-1:0])));
endmodule

// File: tb/sdram_mixmux_tb.sv
`timescale 1ns/1ps
module sdram_mixmux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [21:0] host_addr_i = '0;
  logic        wr_i = 1'b0;
  logic        phase_col_i = 1'b0;
  logic        mixed_i = 1'b0;
  logic        pre_req_i = 1'b0;
  logic [13:0] bus_addr_o;
  logic [1:0]  bank_o;
  logic        page_end_o;
  logic        wr_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sdram_mixmux u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .host_addr_i(host_addr_i),
    .wr_i(wr_i), .phase_col_i(phase_col_i), .mixed_i(mixed_i),
    .pre_req_i(pre_req_i), .bus_addr_o(bus_addr_o), .bank_o(bank_o),
    .page_end_o(page_end_o), .wr_o(wr_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_bus(input int a, input bit ph, input bit mx, input bit pre);
    int row, bank, col, ap;
    row  = a / 1024;
    bank = (a / 256) % 4;
    col  = a % 256;
    if (!ph) return row;
    ap = (mx && bank >= 2) ? 1 : (pre ? 1 : 0);
    return col + (mx ? ((row / 2048) * 256 + (bank / 2) * 512) : 0) + ap * 1024;
  endfunction

  task automatic one_req(input int a, input bit ph, input bit mx, input bit pre, input bit wr);
    int eb;
    int cols[4];
    eb = exp_bus(a, ph, mx, pre);
    host_addr_i = a[21:0]; phase_col_i = ph; mixed_i = mx; pre_req_i = pre; wr_i = wr;
    req_i = 1'b1;
    @(negedge clk);
    if (!ph) begin
      check("R2 row field", int'(bus_addr_o[11:0]), eb % 4096);
      check("R2 upper zero", int'(bus_addr_o[13:12]), 0);
    end else begin
      check("R4 column field", int'(bus_addr_o[7:0]), eb % 256);
      check("R4 high lines zero", int'({bus_addr_o[13:11]}), 0);
      if (mx) check("R5 spare lines", int'(bus_addr_o[9:8]), (eb / 256) % 4);
      else    check("R6 spare lines", int'(bus_addr_o[9:8]), 0);
      if (mx && ((a / 512) % 2 == 1)) check("R7 forced ap", int'(bus_addr_o[10]), 1);
      else check("R8 ap follows request", int'(bus_addr_o[10]), pre ? 1 : 0);
    end
    check("R3 bank", int'(bank_o), (a / 256) % 4);
    check("R9 page end", int'(page_end_o), (a % 256 == 255) ? 1 : 0);
    check("R11 write flag", int'(wr_o), wr ? 1 : 0);
    cols[0] = 0;
    // disturb everything with the strobe low
    req_i = 1'b0;
    host_addr_i = ~a[21:0]; phase_col_i = ~ph; mixed_i = ~mx; pre_req_i = ~pre; wr_i = ~wr;
    @(negedge clk);
    check("R10 hold bus", int'(bus_addr_o), eb + cols[0]);
    check("R10 hold page/wr", int'({page_end_o, wr_o}), ((a % 256 == 255) ? 2 : 0) + (wr ? 1 : 0));
  endtask

  initial begin
    int cvals[4];
    int rvals[4];
    cvals = '{0, 1, 128, 255};
    rvals = '{0, 4095, 2048, 1365};
    repeat (3) @(negedge clk);
    check("R1 reset bus", int'(bus_addr_o), 0);
    check("R1 reset others", int'({bank_o, page_end_o, wr_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'({bus_addr_o, bank_o, page_end_o, wr_o}), 0);
    for (int mx = 0; mx < 2; mx++)
      for (int ph = 0; ph < 2; ph++)
        for (int pre = 0; pre < 2; pre++)
          for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
              for (int r = 0; r < 4; r++)
                one_req(rvals[r] * 1024 + b * 256 + cvals[c], ph[0], mx[0], pre[0], (r + c) % 2 == 1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule